// File: doc/BRIEF.md
# Seven-Source Interrupt Aggregator

This block collects seven interrupt sources into one interrupt request line for the host. Four sources are handshake request lines from two parallel ports and are active high. Three sources are counter/timer outputs. The active level of each counter source is chosen by a polarity bit that the counter routing block supplies. Every source passes through a two-flop synchronizer. A source is recorded as pending when its synchronized level moves into the active state while its enable bit is set. A pending source stays recorded until the host clears it.

The host sees two registers on an 8-bit bus. The enable register at offset 0xC can be read and written. The status register at offset 0xD is read-only. Each register holds one bit per source. To clear a pending source, the host writes 0 to its enable bit and then writes 1 to arm it again; writing to the status register does nothing. The interrupt line is high whenever any source is pending.

Each source is tracked by a small state machine with three states:
- `SRC_OFF`: the source is disabled.
- `SRC_ARMED`: the source is enabled and waiting for an activation.
- `SRC_PEND`: the source is latched and pending.

The transitions are:
- *arm*: `SRC_OFF`→`SRC_ARMED`, when the source is enabled and there is no activation edge.
- *fire*: `SRC_ARMED`→`SRC_PEND`, on an activation edge while enabled.
- *fire-on-arm*: `SRC_OFF`→`SRC_PEND`, when the enable and an activation edge arrive in the same cycle.
- *disarm*: `SRC_ARMED`→`SRC_OFF`, when the enable bit is 0.
- *clear*: `SRC_PEND`→`SRC_OFF`, when the enable bit is 0.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register and the status register both read 0x00 and `irq_o` is low.
- R2: A write to offset 0xC stores bits 6:0 as the enable bits. Reading offset 0xC returns them, and bit 7 reads 0.
- R3: A write to offset 0xD changes neither register. A read from any offset other than 0xC or 0xD returns 0x00.
- R4: The bit assignment is the same in both registers:
  - bit 0 is port-A handshake line 0;
  - bit 1 is port-A handshake line 3;
  - bit 2 is port-B handshake line 0;
  - bit 3 is port-B handshake line 3;
  - bits 4, 5 and 6 are counters 0, 1 and 2.

  On `hs_req_i`, bits 3:0 map to status bits 3:0. On `ctr_out_i` and `ctr_pol_i`, bits 2:0 map to status bits 6:4.
- R5: A handshake source is active high. If its 0→1 input change is driven between clock edges while the source is enabled, its status bit and `irq_o` are still low after the second rising edge and are set after the third rising edge.
- R6: A counter source with polarity bit 1 becomes active when its output goes high. With polarity bit 0 it becomes active when its output goes low. A change toward the inactive level never sets status.
- R7: A set status bit stays set while its enable bit stays 1, whether or not the source level persists or returns to inactive. It does not fire again.
- R8: Writing 0 to an enable bit clears that status bit by the following clock edge. Writing 1 again arms the source, so a later new activation sets the bit again.
- R9: An activation that happens while the source is disabled is not latched. This holds even if the enable bit is set later while the level is still active.
- R10: `irq_o` is high exactly when any status bit is set.
- R11: Bit 7 of the status register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| hs_req_i | input | 4 | Handshake request lines, active high |
| ctr_out_i | input | 3 | Counter/timer outputs |
| ctr_pol_i | input | 3 | Counter active level: 1 = high, 0 = low |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The assertions rely on three assumptions about the inputs:
- Every source level is held for at least two clock cycles, so the synchronizer cannot miss it.
- A polarity bit is changed only while its source is disabled.
- The read address is stable whenever `bus_rdata` is observed.

The stimulus changes sources and polarity only on falling clock edges. It holds each level for four or more cycles, and it sets polarity and idle levels while the enable register is 0. It then waits several cycles before arming, so that a polarity change never appears as an activation.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int HS_N_DEF  = 4;
    localparam int CT_N_DEF  = 3;
    localparam int AW_DEF    = 4;
    localparam int DW_DEF    = 8;
    localparam int SYNC_DEF  = 2;
    localparam logic [3:0] EN_OFS = 4'hC;
    localparam logic [3:0] ST_OFS = 4'hD;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_ARMED = 2'd1,
        SRC_PEND  = 2'd2
    } src_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic act,
    output logic pend
);
    src_state_e state, nxt;
    logic act_q;
    logic rise;

    assign rise = act & ~act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SRC_OFF;
            act_q <= 1'b0;
        end else begin
            state <= nxt;
            act_q <= act;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SRC_OFF: begin
                if (en) nxt = rise ? SRC_PEND : SRC_ARMED;
            end
            SRC_ARMED: begin
                if (!en)       nxt = SRC_OFF;
                else if (rise) nxt = SRC_PEND;
            end
            SRC_PEND: begin
                if (!en) nxt = SRC_OFF;
            end
            default: nxt = SRC_OFF;
        endcase
    end

    always_comb begin
        pend = (state == SRC_PEND);
    end
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
    import irq_agg_pkg::*;
#(
    parameter int SRC_N = 7,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] en_q,
    output logic [DW-1:0]    bus_rdata
);
    localparam logic [AW-1:0] EN_A = AW'(EN_OFS);
    localparam logic [AW-1:0] ST_A = AW'(ST_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           en_q <= '0;
        else if (bus_wr && bus_addr == EN_A)  en_q <= bus_wdata[SRC_N-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == EN_A)      bus_rdata = DW'(en_q);
        else if (bus_addr == ST_A) bus_rdata = DW'(pend);
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int HS_N        = HS_N_DEF,
    parameter int CT_N        = CT_N_DEF,
    parameter int AW          = AW_DEF,
    parameter int DW          = DW_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [HS_N-1:0] hs_req_i,
    input  logic [CT_N-1:0] ctr_out_i,
    input  logic [CT_N-1:0] ctr_pol_i,
    output logic            irq_o
);
    localparam int SRC_N = HS_N + CT_N;

    logic [SRC_N-1:0] raw_sync;
    logic [SRC_N-1:0] act;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] en_q;

    irq_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctr_out_i, hs_req_i}),
        .dout (raw_sync)
    );

    // handshake lines are active high; counter lines follow their polarity bit
    assign act = {~(raw_sync[SRC_N-1:HS_N] ^ ctr_pol_i), raw_sync[HS_N-1:0]};

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        irq_src_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_q[i]),
            .act  (act[i]),
            .pend (pend[i])
        );
    end

    irq_host_regs #(.SRC_N(SRC_N), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .pend     (pend),
        .en_q     (en_q),
        .bus_rdata(bus_rdata)
    );

    assign irq_o = |pend;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int SRC_N = 7,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] en_q,
    input logic [SRC_N-1:0] pend,
    input logic [SRC_N-1:0] act,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_rdata
);
    // R8: a source whose enable was 0 on the previous cycle is not pending
    a_r8_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(en_q)) == '0);

    // R7: pending with enable held stays pending
    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & $past(en_q) & ~pend) == '0);

    // R5, R9: a new pending bit needs an active, enabled source the cycle before
    a_r5_set_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~($past(act) & $past(en_q))) == '0);

    // R11: unused status bits read as zero
    a_r11_status_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(ST_OFS)) |-> (bus_rdata[DW-1:SRC_N] == '0));
endmodule

bind irq_aggregator irq_agg_chk #(.SRC_N(SRC_N), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .pend     (pend),
    .act      (act),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    localparam logic [3:0] A_EN = 4'hC;
    localparam logic [3:0] A_ST = 4'hD;
    localparam int NV = 6;
    // {enable[27:20], hs[19:16], ctr fire[15:12], pol[11:8], expected status[7:0]}
    localparam logic [27:0] VEC [NV] = '{
        {8'h7F, 4'hF, 4'h7, 4'h7, 8'h7F},
        {8'h55, 4'h5, 4'h0, 4'h0, 8'h05},
        {8'h2A, 4'hF, 4'h7, 4'h0, 8'h2A},
        {8'h70, 4'h0, 4'h5, 4'h2, 8'h50},
        {8'h0F, 4'h0, 4'h7, 4'h5, 8'h00},
        {8'hFF, 4'h8, 4'h2, 4'h7, 8'h28}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] hs_req_i = '0;
    logic [2:0] ctr_out_i = '0;
    logic [2:0] ctr_pol_i = '1;
    logic       irq_o;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_req_i(hs_req_i),
        .ctr_out_i(ctr_out_i), .ctr_pol_i(ctr_pol_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [27:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(A_EN, d); chk("R1 enable after reset", d, 8'h00);
        rd_reg(A_ST, d); chk("R1 status after reset", d, 8'h00);
        chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

        // vector table: R2 R4 R6 R10
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            wr_reg(A_EN, 8'h00);
            ctr_pol_i = v[10:8]; hs_req_i = '0; ctr_out_i = ~v[10:8];
            wait_cyc(4);
            wr_reg(A_EN, v[27:20]);
            wait_cyc(1);
            hs_req_i = v[19:16]; ctr_out_i = ~v[10:8] ^ v[14:12];
            wait_cyc(4);
            rd_reg(A_ST, d); chk("R4 status map", d, v[7:0]);
            chk("R10 irq vs status", {7'd0, irq_o}, {7'd0, v[7:0] != 8'h00});
            rd_reg(A_EN, d); chk("R2 enable readback", d, v[27:20] & 8'h7F);
        end

        // R7 hold after source returns inactive
        wr_reg(A_EN, 8'h00);
        hs_req_i = '0; ctr_pol_i = 3'b111; ctr_out_i = 3'b000;
        wait_cyc(4);
        wr_reg(A_EN, 8'h01);
        hs_req_i[0] = 1'b1; wait_cyc(4);
        hs_req_i[0] = 1'b0; wait_cyc(4);
        rd_reg(A_ST, d); chk("R7 held after source drop", d, 8'h01);
        hs_req_i[0] = 1'b1; wait_cyc(4);
        rd_reg(A_ST, d); chk("R7 no refire while set", d, 8'h01);
        hs_req_i[0] = 1'b0; wait_cyc(4);

        // R8 clear pulse and re-arm
        wr_reg(A_EN, 8'h00);
        wr_reg(A_EN, 8'h01);
        rd_reg(A_ST, d); chk("R8 cleared by enable pulse", d, 8'h00);
        chk("R10 irq low after clear", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        hs_req_i[0] = 1'b1;
        wait_cyc(2); chk("R5 not yet after two edges", {7'd0, irq_o}, 8'h00);
        wait_cyc(1); chk("R5 set after third edge", {7'd0, irq_o}, 8'h01);
        rd_reg(A_ST, d); chk("R8 re-armed source fires", d, 8'h01);

        // R9 enable while level already active
        wr_reg(A_EN, 8'h00);
        wr_reg(A_EN, 8'h01);
        wait_cyc(4);
        rd_reg(A_ST, d); chk("R9 held level not latched on enable", d, 8'h00);
        wr_reg(A_EN, 8'h00);
        hs_req_i[1] = 1'b1; wait_cyc(4);
        wr_reg(A_EN, 8'h02); wait_cyc(4);
        rd_reg(A_ST, d); chk("R9 activation while disabled dropped", d, 8'h00);

        // R6 low polarity
        wr_reg(A_EN, 8'h00);
        hs_req_i = '0; ctr_pol_i[0] = 1'b0; ctr_out_i[0] = 1'b1;
        wait_cyc(4);
        wr_reg(A_EN, 8'h10);
        ctr_out_i[0] = 1'b0; wait_cyc(4);
        rd_reg(A_ST, d); chk("R6 low polarity fires on fall", d, 8'h10);
        wr_reg(A_EN, 8'h00);
        wr_reg(A_EN, 8'h10);
        ctr_out_i[0] = 1'b1; wait_cyc(4);
        rd_reg(A_ST, d); chk("R6 low polarity ignores rise", d, 8'h00);

        // R3 status is read-only, other offsets read zero
        wr_reg(A_ST, 8'hFF);
        rd_reg(A_ST, d); chk("R3 status write ignored", d, 8'h00);
        rd_reg(A_EN, d); chk("R3 enable unchanged by status write", d, 8'h10);
        rd_reg(4'h0, d); chk("R3 other offset reads zero", d, 8'h00);

        // R11 bit 7 of status
        wr_reg(A_EN, 8'hFF);
        hs_req_i = 4'hF; wait_cyc(4);
        rd_reg(A_ST, d); chk("R11 status bit7 zero", d, 8'h0F);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(2); rst_n = 1'b1;
        rd_reg(A_EN, d); chk("R1 enable after second reset", d, 8'h00);
        rd_reg(A_ST, d); chk("R1 status after second reset", d, 8'h00);
        chk("R1 irq after second reset", {7'd0, irq_o}, 8'h00);

        done = 1'b1;
        report();
        $finish;
    end
endmodule